// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits between a serial-bus protocol engine and a byte-wide nonvolatile array. The protocol engine reports a new write command with its target address, then strobes each received data byte. The block stores those bytes in a small page latch, and it starts a commit cycle when the stop event arrives. During that cycle the stored bytes go out on a simple array write port, and the block then stays busy for a fixed internal write time counted in timing ticks.

Only the low address bits advance while bytes arrive, so the address wraps within the page. Bytes beyond a page's worth overwrite the earliest slots. A write-protect input has no effect until the first data byte is captured. From that capture until the end of the write time, a high level on it cancels the cycle at once: busy drops and an abort flag is raised. A low-supply flag present at the stop event suppresses the cycle.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_we` and `wr_aborted` are 0.
- R2: The byte strobed k-th after a command load (k from 0) goes to slot (low four bits of `cmd_addr` + k) mod 16. `mem_addr` is formed from the upper bits of `cmd_addr` with the slot index in its low four bits, so the upper bits never change within one cycle.
- R3: When more than 16 bytes arrive, a later byte replaces the earlier byte in the same slot, and only the last value is committed.
- R4: A commit writes each received slot exactly once, in ascending slot order, one per clock, starting the cycle after the stop event. Slots that received no byte are not written.
- R5: A stop event that arrives when no data byte has been received since the command load starts no commit cycle: `busy` stays 0 and nothing is written.
- R6: `busy` is 1 for exactly PAGE_BYTES clocks of scan plus WRITE_TICKS ticks of hold. A command load during `busy` is ignored: later bytes and a later stop cause no write.
- R7: A high level on `wp` between the command load and the first byte strobe has no effect on the write.
- R8: `wp` high on or after the first byte strobe, or at any time while `busy` is 1, aborts the cycle. `busy` is 0 on the next clock, `wr_aborted` becomes 1, no further array write happens, and bytes and a stop that follow before the next command load are ignored.
- R9: `low_supply` high in the stop-event cycle suppresses the commit cycle completely.
- R10: `wr_aborted` is cleared by the next accepted command load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Pulse: new write command with address |
| cmd_addr | input | ADDR_W | Start address of the command |
| byte_vld | input | 1 | Pulse: data byte captured (its last bit clocked in) |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| wp | input | 1 | Write-protect level |
| low_supply | input | 1 | Supply-below-threshold flag |
| tick | input | 1 | Timing tick for the write-time counter |
| busy | output | 1 | Internal write in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| wr_aborted | output | 1 | Last cycle was cancelled by write protect |

## Verification
The properties assume that the protocol engine issues `cmd_load`, `byte_vld` and `stop_evt` as single-cycle pulses and never raises two of them in the same cycle. They also assume that `wp` is a clean level sampled on the clock. The stimulus meets these assumptions by driving every pulse for exactly one cycle on the falling edge, separated by random gaps. It raises `wp` only in isolated one-cycle windows placed before the first byte, after a chosen byte, or inside the hold phase. Random start addresses and byte counts of up to 40 exercise the wrap, the overwrite and the empty-stop paths.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SCAN   = 2'd2,
        ST_HOLD   = 2'd3
    } pcc_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } slot_rd_t;

    function automatic logic [7:0] slot_step(input logic [7:0] idx, input int unsigned width);
        logic [7:0] mask;
        mask = 8'((1 << width) - 1);
        return (idx + 8'd1) & mask;
    endfunction

endpackage

// File: rtl/pcc_page_latch.sv
module pcc_page_latch #(
    parameter int SLOTS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output pcc_pkg::slot_rd_t rd,
    output logic             any_valid
);
    logic [7:0]       store [SLOTS];
    logic [SLOTS-1:0] vmask;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vmask <= '0;
        end else if (wr_en) begin
            vmask[wr_idx] <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    store[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd.data  = store[rd_idx];
        rd.valid = vmask[rd_idx];
        any_valid = |vmask;
    end
endmodule

// File: rtl/pcc_hold_timer.sv
module pcc_hold_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = run && tick && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 16,
    parameter int WRITE_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_load,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              stop_evt,
    input  logic              wp,
    input  logic              low_supply,
    input  logic              tick,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              wr_aborted
);
    import pcc_pkg::*;

    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - IDX_W;

    pcc_state_e       state;
    logic [HI_W-1:0]  page_hi;
    logic [IDX_W-1:0] fill_ptr;
    logic [IDX_W-1:0] scan_idx;
    logic             armed;
    logic             aborted_q;
    slot_rd_t         slot_rd;
    logic             any_valid;
    logic             hold_done;
    logic             latch_clr;
    logic             latch_we;
    logic             cancel;

    assign latch_clr = cmd_load && (state == ST_IDLE || state == ST_FILL);
    assign cancel    = wp && ((state == ST_FILL && (armed || byte_vld)) ||
                              state == ST_SCAN || state == ST_HOLD);
    assign latch_we  = (state == ST_FILL) && byte_vld && !cmd_load && !cancel && !stop_evt;

    pcc_page_latch #(.SLOTS(PAGE_BYTES), .IDX_W(IDX_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .clr       (latch_clr),
        .wr_en     (latch_we),
        .wr_idx    (fill_ptr),
        .wr_data   (byte_data),
        .rd_idx    (scan_idx),
        .rd        (slot_rd),
        .any_valid (any_valid)
    );

    pcc_hold_timer #(.TICKS(WRITE_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_HOLD),
        .tick (tick),
        .done (hold_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            page_hi   <= '0;
            fill_ptr  <= '0;
            scan_idx  <= '0;
            armed     <= 1'b0;
            aborted_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_load) begin
                        page_hi   <= cmd_addr[ADDR_W-1:IDX_W];
                        fill_ptr  <= cmd_addr[IDX_W-1:0];
                        armed     <= 1'b0;
                        aborted_q <= 1'b0;
                        state     <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (cmd_load) begin
                        page_hi   <= cmd_addr[ADDR_W-1:IDX_W];
                        fill_ptr  <= cmd_addr[IDX_W-1:0];
                        armed     <= 1'b0;
                        aborted_q <= 1'b0;
                    end else if (cancel) begin
                        aborted_q <= 1'b1;
                        armed     <= 1'b0;
                        state     <= ST_IDLE;
                    end else if (stop_evt) begin
                        armed    <= 1'b0;
                        scan_idx <= '0;
                        state    <= (any_valid && !low_supply) ? ST_SCAN : ST_IDLE;
                    end else if (byte_vld) begin
                        fill_ptr <= IDX_W'(slot_step(8'(fill_ptr), IDX_W));
                        armed    <= 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (cancel) begin
                        aborted_q <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (scan_idx == IDX_W'(PAGE_BYTES - 1)) begin
                        state <= ST_HOLD;
                    end else begin
                        scan_idx <= scan_idx + IDX_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cancel) begin
                        aborted_q <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (hold_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_SCAN) || (state == ST_HOLD);
    assign mem_we     = (state == ST_SCAN) && slot_rd.valid && !wp;
    assign mem_addr   = {page_hi, scan_idx};
    assign mem_wdata  = slot_rd.data;
    assign wr_aborted = aborted_q;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_evt,
    input logic              wp,
    input logic              low_supply,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_aborted
);
    assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    assert_wp_ends_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && wp) |=> !busy);

    assert_abort_needs_wp_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_aborted) |-> $past(wp));

    assert_low_supply_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && low_supply && !busy) |=> !busy);

    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            mem_addr[ADDR_W-1:IDX_W] == $past(mem_addr[ADDR_W-1:IDX_W]));
endmodule

bind page_commit_ctrl pcc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_page_commit_ctrl.sv
module sim_page_commit_ctrl;
    localparam int AW = 11;
    localparam int PG = 16;
    localparam int T  = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_load = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop_evt = 1'b0;
    logic          wp = 1'b0;
    logic          low_supply = 1'b0;
    logic          tick = 1'b1;
    logic          busy, mem_we, wr_aborted;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int rec_cnt = 0;
    logic [AW-1:0] rec_addr [64];
    logic [7:0]    rec_data [64];

    always #2 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PG), .WRITE_TICKS(T)) u0 (.*);

    always @(negedge clk) begin
        if (mem_we && rec_cnt < 64) begin
            rec_addr[rec_cnt] = mem_addr;
            rec_data[rec_cnt] = mem_wdata;
            rec_cnt = rec_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_of(input int addr, input int k);
        return (addr + k) % PG;
    endfunction

    // mode: 0 plain, 1 wp before first byte, 2 wp after byte j, 3 wp in hold, 4 load while busy
    task automatic run_cmd(input int addr, input int n, input int mode, input int j, input bit lv);
        logic [7:0] ed [PG];
        bit ev [PG];
        bit live;
        bit exp_wr;
        int bc, k, snap;
        for (int s = 0; s < PG; s++) begin ev[s] = 0; ed[s] = 0; end
        rec_cnt = 0;
        live = 1;
        @(negedge clk);
        cmd_load = 1; cmd_addr = AW'(addr);
        @(negedge clk);
        cmd_load = 0;
        chk(wr_aborted == 0, "R10 abort flag cleared by load", wr_aborted, 0);
        if (mode == 1) begin wp = 1; @(negedge clk); wp = 0; end
        for (int i = 0; i < n; i++) begin
            byte_vld = 1; byte_data = 8'($urandom);
            if (live) begin ev[slot_of(addr, i)] = 1; ed[slot_of(addr, i)] = byte_data; end
            @(negedge clk);
            byte_vld = 0;
            if (mode == 2 && i + 1 == j) begin wp = 1; @(negedge clk); wp = 0; live = 0; end
            repeat ($urandom % 3) @(negedge clk);
        end
        stop_evt = 1; low_supply = lv;
        @(negedge clk);
        stop_evt = 0; low_supply = 0;
        exp_wr = (n > 0) && !lv && (mode != 2);
        bc = 0;
        while (busy && bc < 500) begin
            bc++;
            if (mode == 3 && bc == PG + 2) begin
                wp = 1; @(negedge clk); wp = 0;
            end else if (mode == 4 && bc == 5) begin
                cmd_load = 1; cmd_addr = AW'(addr ^ 5); @(negedge clk); cmd_load = 0;
            end else begin
                @(negedge clk);
            end
        end
        if (!exp_wr) begin
            chk(bc == 0, "R5 R8 R9 no busy without commit", bc, 0);
            chk(rec_cnt == 0, "R5 R8 R9 no array write", rec_cnt, 0);
        end else begin
            if (mode == 3) begin
                chk(bc == PG + 2, "R8 busy drops after wp in hold", bc, PG + 2);
                chk(wr_aborted == 1, "R8 abort flag set", wr_aborted, 1);
            end else begin
                chk(bc == PG + T, "R6 busy length", bc, PG + T);
                chk(wr_aborted == 0, "R7 no abort", wr_aborted, 0);
            end
            k = 0;
            for (int s = 0; s < PG; s++) begin
                if (ev[s]) begin
                    chk(rec_addr[k] == AW'(((addr / PG) * PG) + s), "R2 R4 write address",
                        int'(rec_addr[k]), ((addr / PG) * PG) + s);
                    chk(rec_data[k] == ed[s], "R3 R4 write data", int'(rec_data[k]), int'(ed[s]));
                    k++;
                end
            end
            chk(rec_cnt == k, "R4 write count", rec_cnt, k);
        end
        if (mode == 2) chk(wr_aborted == 1, "R8 abort during fill", wr_aborted, 1);
        if (mode == 4) begin
            snap = rec_cnt;
            byte_vld = 1; @(negedge clk); byte_vld = 0;
            stop_evt = 1; @(negedge clk); stop_evt = 0;
            repeat (3) @(negedge clk);
            chk(busy == 0, "R6 load during busy ignored", busy, 0);
            chk(rec_cnt == snap, "R6 no write after ignored load", rec_cnt, snap);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
        chk(wr_aborted == 0, "R1 abort flag after reset", wr_aborted, 0);

        run_cmd(12'h0E, 4, 0, 0, 0);     // R2 wrap 0E,0F,00,01
        run_cmd(12'h123, 1, 0, 0, 0);    // single byte
        run_cmd(12'h35, 20, 0, 0, 0);    // R3 overwrite
        run_cmd(12'h40, 0, 0, 0, 0);     // R5 empty stop
        run_cmd(12'h51, 5, 0, 0, 1);     // R9 low supply
        run_cmd(12'h60, 3, 1, 0, 0);     // R7 wp before first byte
        run_cmd(12'h77, 6, 2, 2, 0);     // R8 abort in fill
        run_cmd(12'h7A, 9, 0, 0, 0);     // R10 after abort
        run_cmd(12'h88, 16, 3, 0, 0);    // R8 abort in hold
        run_cmd(12'h90, 2, 4, 0, 0);     // R6 load while busy

        for (int r = 0; r < 30; r++) begin
            int md, nb;
            md = int'($urandom % 4);
            nb = int'($urandom % 41);
            if (md == 2 && nb == 0) nb = 1;
            run_cmd(int'($urandom % (1 << AW)), nb, md,
                    1 + int'($urandom % (nb > 0 ? nb : 1)), ($urandom % 8) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule